// File: doc/BRIEF.md
# Four-Channel Compare Timer

A free-running up-counter with four compare channels, controlled through a small word-addressed register bus. Software starts, halts or zeroes the counter by writing a trigger value to one of three task addresses. Software also picks the counter width and a power-of-two prescaler. A one-cycle-wide base tick (`tick_i`) drives the counting. Each step of the counter is taken every 2^prescaler base ticks while the counter runs.

Each channel holds a 32-bit compare value and a sticky event flag. The flag is raised on the step that carries the counter onto the compare value, including a step that wraps the counter through zero. The flag stays set until software writes zero to it. The flags are also available as a parallel output for wiring to neighbouring logic.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter is halted at 0. The width selection (address 3), the prescaler (address 4), all compare values (addresses 8..11) and all event flags (addresses 12..15) read 0, and `evt_o` is 0.
- R2: A bus write with `bus_wdata[0]`=1 to address 0 starts counting, to address 1 halts it, and to address 2 zeroes the counter and the prescaler phase. A write with bit 0 clear to any of these has no effect. A zeroing write that coincides with a counter step wins, and that step raises no event.
- R3: Address 3 bits [1:0] select the width: 0 = 16-bit, 1 = 8-bit, 2 = 24-bit, 3 = 32-bit. The counter goes from its all-ones value for the selected width back to 0 on the next step.
- R4: Address 4 holds the prescaler p. While running, the counter advances once every 2^p cycles in which `tick_i` is 1. With p = 0 it advances on every tick.
- R5: The event flag of channel i reads at address 12+i as 1 (bit 0) once raised. It stays 1 until a bus write of value 0 to that address. A nonzero write there has no effect.
- R6: The event of channel i is raised on the step where the counter moves onto the compare value at address 8+i. All 32 bits take part in the comparison. A counter that stays on that value raises it only once.
- R7: No event is raised while the counter is below the compare value, including the step that leaves it one count short.
- R8: A compare value written below the current count raises its event only after the counter has wrapped and climbed to it.
- R9: When a step raises an event in the same cycle as a bus write of 0 to that event address, the flag ends up 1.
- R10: `evt_o[i]` always equals the event flag of channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base tick, one clock wide per tick |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_o | output | 4 | Event flags, bit i for channel i |

## Verification
Two functions can land on the same clock edge: a counter step that raises a channel event, and a software write that clears that same flag. The same holds for a step and a zeroing task. The bench lines the counter up one count below a compare value. It then issues the clearing or zeroing write in exactly the cycle that carries a tick. It judges the outcome against a bench-side model in which the hardware set beats the software clear, and the zeroing task beats the step. Random traffic with frequent 8-bit wraps keeps provoking further collisions of this kind, and the model checks every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 4;

  typedef enum logic [1:0] {
    WID_16 = 2'd0,
    WID_8  = 2'd1,
    WID_24 = 2'd2,
    WID_32 = 2'd3
  } width_e;

  localparam logic [3:0] A_START = 4'd0;
  localparam logic [3:0] A_STOP  = 4'd1;
  localparam logic [3:0] A_CLEAR = 4'd2;
  localparam logic [3:0] A_MODE  = 4'd3;
  localparam logic [3:0] A_PRESC = 4'd4;
  localparam logic [1:0] A_CC_HI = 2'b10;
  localparam logic [1:0] A_EV_HI = 2'b11;

  function automatic logic [31:0] width_mask(input logic [1:0] m);
    case (width_e'(m))
      WID_8:   return 32'h0000_00FF;
      WID_24:  return 32'h00FF_FFFF;
      WID_32:  return 32'hFFFF_FFFF;
      default: return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] step_value(input logic [31:0] cur, input logic [1:0] m);
    return (cur + 32'd1) & width_mask(m);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            step
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim  = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
  assign step = run & tick & (div_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)          div_q <= '0;
    else if (clr)        div_q <= '0;
    else if (run & tick) div_q <= step ? '0 : div_q + DIV_W'(1);
  end

  AST_STEP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ps != '0 && !clr) |=> (!step || ps == '0)); // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        clr,
  input  logic [1:0]  mode,
  output logic [31:0] cnt,
  output logic [31:0] nxt
);
  assign nxt = step_value(cnt, mode);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= nxt;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == 32'd0); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && cnt == width_mask(mode)) |=> cnt == 32'd0); // R3
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        clr,
  input  logic [31:0] nxt,
  input  logic [31:0] cur,
  input  logic        cc_we,
  input  logic        ev_we,
  input  logic [31:0] wd,
  output logic [31:0] cc,
  output logic        ev,
  output logic        hit
);
  assign hit = step & ~clr & (nxt == cc);

  always_ff @(posedge clk) begin
    if (!rst_n)     cc <= '0;
    else if (cc_we) cc <= wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ev <= 1'b0;
    else if (hit)                    ev <= 1'b1;
    else if (ev_we && wd == 32'd0)   ev <= 1'b0;
  end

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !(ev_we && wd == 32'd0)) |=> ev); // R5
  AST_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev) |-> $past(hit)); // R6
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ev) && $stable(cc)) |-> cur == cc); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ev_we) |=> ev); // R9
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  evt_o
);
  logic            run_q;
  logic [1:0]      mode_q;
  logic [PS_W-1:0] ps_q;

  logic            t_start, t_stop, t_clear;
  logic            step_w;
  logic [31:0]     cnt_w, nxt_w;
  logic [31:0]     cc_w [NCH];
  logic [NCH-1:0]  ev_w, hit_w;

  assign t_start = bus_we && bus_addr == A_START && bus_wdata[0];
  assign t_stop  = bus_we && bus_addr == A_STOP  && bus_wdata[0];
  assign t_clear = bus_we && bus_addr == A_CLEAR && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 2'd0;
      ps_q   <= '0;
    end else begin
      if (t_stop)       run_q <= 1'b0;
      else if (t_start) run_q <= 1'b1;
      if (bus_we && bus_addr == A_MODE)  mode_q <= bus_wdata[1:0];
      if (bus_we && bus_addr == A_PRESC) ps_q   <= bus_wdata[PS_W-1:0];
    end
  end

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_i),
    .clr(t_clear), .ps(ps_q), .step(step_w)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step_w), .clr(t_clear),
    .mode(mode_q), .cnt(cnt_w), .nxt(nxt_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cc_we_i, ev_we_i;
    assign cc_we_i = bus_we && bus_addr == {A_CC_HI, 2'(i)};
    assign ev_we_i = bus_we && bus_addr == {A_EV_HI, 2'(i)};
    tmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .step(step_w), .clr(t_clear),
      .nxt(nxt_w), .cur(cnt_w), .cc_we(cc_we_i), .ev_we(ev_we_i),
      .wd(bus_wdata), .cc(cc_w[i]), .ev(ev_w[i]), .hit(hit_w[i])
    );
  end

  assign evt_o = ev_w;

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == A_MODE)             bus_rdata = {30'd0, mode_q};
    else if (bus_addr == A_PRESC)       bus_rdata = 32'(ps_q);
    else if (bus_addr[3:2] == A_CC_HI)  bus_rdata = cc_w[bus_addr[1:0]];
    else if (bus_addr[3:2] == A_EV_HI)  bus_rdata = {31'd0, ev_w[bus_addr[1:0]]};
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !t_clear) |=> $stable(cnt_w)); // R2
  AST_NO_HIT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> hit_w == '0); // R2
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model
  bit          m_run;
  logic [31:0] m_cnt;
  logic [1:0]  m_mode;
  logic [3:0]  m_ps;
  int unsigned m_div;
  logic [31:0] m_cc [4];
  logic [3:0]  m_ev;

  cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_o(evt_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mmask(input logic [1:0] m);
    if (m == 2'd1) return 32'hFF;
    if (m == 2'd2) return 32'hFF_FFFF;
    if (m == 2'd3) return 32'hFFFF_FFFF;
    return 32'hFFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit tk, input bit w, input logic [3:0] a, input logic [31:0] d);
    bit st, sp, cl, stp;
    logic [31:0] nx;
    st  = w && a == 4'd0 && d[0];
    sp  = w && a == 4'd1 && d[0];
    cl  = w && a == 4'd2 && d[0];
    nx  = (m_cnt + 32'd1) & mmask(m_mode);
    stp = m_run && tk && (m_div == (32'd1 << m_ps) - 1);
    for (int i = 0; i < 4; i++) begin
      if (stp && !cl && nx == m_cc[i]) m_ev[i] = 1'b1;
      else if (w && a == 4'(12 + i) && d == 32'd0) m_ev[i] = 1'b0;
    end
    if (cl) m_cnt = 32'd0; else if (stp) m_cnt = nx;
    if (cl) m_div = 0; else if (m_run && tk) m_div = stp ? 0 : m_div + 1;
    if (sp) m_run = 1'b0; else if (st) m_run = 1'b1;
    for (int i = 0; i < 4; i++) if (w && a == 4'(8 + i)) m_cc[i] = d;
    if (w && a == 4'd3) m_mode = d[1:0];
    if (w && a == 4'd4) m_ps = d[3:0];
  endtask

  task automatic cyc(input bit tk, input bit w, input logic [3:0] a, input logic [31:0] d);
    tick_i = tk; bus_we = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(tk, w, a, d);
    @(negedge clk);
    tick_i = 1'b0; bus_we = 1'b0;
    chk("R10 evt_o vs model", {28'd0, evt_o}, {28'd0, m_ev});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int k = 0; k < n; k++) cyc(tk, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_run = 0; m_cnt = 0; m_mode = 0; m_ps = 0; m_div = 0; m_ev = 0;
    for (int i = 0; i < 4; i++) m_cc[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd3, 0, "R1 mode"); rd(4'd4, 0, "R1 presc");
    for (int i = 0; i < 4; i++) begin
      rd(4'(8 + i), 0, "R1 cc");
      rd(4'(12 + i), 0, "R1 event");
    end
    chk("R1 evt_o", {28'd0, evt_o}, 0);

    // R6/R7: 8-bit, cc0=5
    wr(4'd3, 1); wr(4'd8, 5); wr(4'd0, 1);
    idle(4, 1); rd(4'd12, 0, "R7 one short");
    idle(1, 1); rd(4'd12, 1, "R6 hit on arrival");

    // R5 sticky
    wr(4'd12, 1); rd(4'd12, 1, "R5 nonzero write ignored");
    idle(3, 0);   rd(4'd12, 1, "R5 holds");
    wr(4'd12, 0); rd(4'd12, 0, "R5 cleared by zero");

    // R2 halt, ignored trigger; R6 once per arrival
    wr(4'd1, 1); idle(10, 1); rd(4'd12, 0, "R2 halted no step");
    wr(4'd0, 0); idle(5, 1);  rd(4'd12, 0, "R2 start bit0=0 ignored");
    wr(4'd0, 1); idle(255, 1); rd(4'd12, 0, "R3 8-bit before return");
    idle(1, 1); rd(4'd12, 1, "R3 8-bit wrap reaches 5 again");

    // R8 compare below count
    wr(4'd9, 2); wr(4'd13, 0);
    idle(252, 1); rd(4'd13, 0, "R8 not before wrap");
    idle(1, 1);   rd(4'd13, 1, "R8 after wrap");

    // R4 prescaler 2
    wr(4'd1, 1); wr(4'd2, 1); wr(4'd4, 2); wr(4'd10, 3); wr(4'd14, 0); wr(4'd0, 1);
    idle(11, 1); rd(4'd14, 0, "R4 11 ticks");
    idle(1, 1);  rd(4'd14, 1, "R4 12 ticks");

    // R9 set beats clear
    wr(4'd1, 1); wr(4'd2, 1); wr(4'd4, 0); wr(4'd11, 3); wr(4'd15, 0); wr(4'd0, 1);
    idle(2, 1); cyc(1'b1, 1'b1, 4'd15, 0); rd(4'd15, 1, "R9 set wins");

    // R2 clear beats step
    wr(4'd8, 4); wr(4'd12, 0);
    cyc(1'b1, 1'b1, 4'd2, 1); rd(4'd12, 0, "R2 clear beats step");
    idle(3, 1); rd(4'd12, 0, "R2 from zero");
    idle(1, 1); rd(4'd12, 1, "R2 counts from zero");

    // R6 full-width compare, R3 16-bit
    wr(4'd10, 300); wr(4'd14, 0); idle(600, 1); rd(4'd14, 0, "R6 300 unreachable in 8-bit");
    wr(4'd1, 1); wr(4'd2, 1); wr(4'd3, 0); rd(4'd3, 0, "R3 mode");
    wr(4'd0, 1); idle(299, 1); rd(4'd14, 0, "R3 16-bit 299");
    idle(1, 1); rd(4'd14, 1, "R3 16-bit 300");
    wr(4'd11, 0); wr(4'd15, 0);
    idle(65235, 1); rd(4'd15, 0, "R3 16-bit at max");
    idle(1, 1);     rd(4'd15, 1, "R3 16-bit wrap to 0");

    // random traffic, 8-bit
    wr(4'd1, 1); wr(4'd2, 1); wr(4'd3, 1);
    for (int k = 0; k < 4000; k++) begin
      bit tk, w;
      logic [3:0] a;
      logic [31:0] d;
      int pick;
      tk = ($urandom % 4) != 0;
      w  = ($urandom % 6) == 0;
      pick = $urandom % 12;
      a = (pick < 3) ? 4'(pick) : (pick == 3) ? 4'd4 : 4'(pick + 4);
      if (a >= 8 && a < 12) d = $urandom % 256;
      else if (a == 4'd4) d = $urandom % 3;
      else if (a == 4'd0) d = 1;
      else d = $urandom % 2;
      cyc(tk, w, a, d);
    end
    for (int i = 0; i < 4; i++) begin
      rd(4'(8 + i), m_cc[i], "R6 cc after random");
      rd(4'(12 + i), {31'd0, m_ev[i]}, "R5 event after random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule